// File: doc/BRIEF.md
# Flow-Through Burst SRAM with Zero Turnaround

This block models a synchronous single-port static memory whose reads and writes can be mixed on consecutive clocks with no idle cycles between them. Every command, address, byte-lane select and write-data input is captured on the rising clock. Read data is flow-through: the array is read combinationally from the captured address, so a read's word appears during the cycle that follows its command edge. A write is split over two edges. Its address and command are captured on one edge, and its data and lane selects on the next. The captured write is held in a small pending register and reaches the array on the following enabled edge. A read that lands on a pending write gets the merged pending data.

The word is four 9-bit lanes wide. The shared bidirectional data pin is modelled as a write-data input, a read-data output and a driver-enable output. A short four-beat burst can follow any loaded command. The low two address bits step in either linear or interleaved order, and each beat repeats the read or write type of the load. A clock enable freezes all state. Three synchronous chip enables and an asynchronous output enable control selection and the drivers.

Top module: `fzb_sram`

## Requirements
- R1: After reset is released, no command is active and no write is pending: drive_en is 0 and rdata is 0 until a read is captured.
- R2: A read captured on an enabled edge (selected, burst_adv=0, wr_n=1) makes drive_en 1 (when out_en_n=0) in the following cycle, and rdata then shows the stored word at the captured address, with no added register stage.
- R3: A write captured on edge N (selected, burst_adv=0, wr_n=0) takes its data from wdata and its lane selects from lane_n on the next enabled edge. lane_n bit i is active low and covers wdata bits [9i+8:9i]. Lanes with lane_n bit i high keep their old contents.
- R4: Reads and writes may follow each other on consecutive enabled edges in any order and to any address, each delivering one word per cycle.
- R5: A read of the address of a write whose data was captured but not yet stored returns the merged word: new data in the selected lanes and old data in the others.
- R6: In the cycle after a write command is captured, and during each write burst beat, drive_en is 0 regardless of out_en_n.
- R7: The device is selected only when sel1_n=0, sel2=1 and sel3_n=0 are all sampled together. An edge without selection leaves the next cycle idle (drive_en 0, rdata 0) and ends any burst.
- R8: out_en_n=1 forces drive_en to 0 and rdata to 0 at once, without a clock. Whenever drive_en is 0, rdata is 0.
- R9: With burst_adv=1 after a load, each enabled edge moves to the next beat k=1,2,3,0,… The upper address bits stay those of the load. The low two bits are (start+k) mod 4 when order_sel was 0 at the load (linear), and start XOR k when order_sel was 1 (interleaved).
- R10: An advance repeats the read or write type of the last loaded command. An advance with no live burst (after reset or a deselect) is idle.
- R11: With clk_en=0 the edge is ignored. The command, burst position, pending write and array all hold, rdata and drive_en keep their values, and wdata is not sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Clock qualifier; 0 stalls the block |
| addr | input | 6 | Word address, taken on load cycles |
| wr_n | input | 1 | Active-low write command, taken on load cycles |
| lane_n | input | 4 | Active-low lane selects for a write's data phase |
| burst_adv | input | 1 | 1 advances the burst, 0 loads a new command |
| order_sel | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| sel1_n | input | 1 | Active-low chip select |
| sel2 | input | 1 | Active-high chip select |
| sel3_n | input | 1 | Active-low chip select |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| wdata | input | 36 | Write data for the write captured on the previous enabled edge |
| rdata | output | 36 | Read word; 0 when not driving |
| drive_en | output | 1 | Data-pin driver enable |

## Verification
Several rules are checked on every cycle. Write data phases and deselected cycles never drive, a captured read drives unless out_en_n is high, out_en_n alone turns the drivers off, a stalled edge holds the outputs, and an advance right after a deselect stays idle. Data values are shown only by the bench's scenarios. These cover a full array fill and readback, a sweep of every lane-select pattern with immediate and delayed readback for the bypass merge, every start offset in both burst orders including the wrap, stalls inside read bursts and inside a write data phase, and all chip-enable combinations.

// File: rtl/fzb_pkg.sv
package fzb_pkg;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    // low two address bits of burst beat k from a start offset
    function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                            input logic [1:0] k,
                                            input burst_order_e ord);
        logic [1:0] r;
        if (ord == ORD_INTERLEAVE) r = start ^ k;
        else                       r = start + k;
        return r;
    endfunction

endpackage

// File: rtl/fzb_burst_addr.sv
module fzb_burst_addr
    import fzb_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [1:0]        beat,
    input  burst_order_e      ord,
    output logic [ADDR_W-1:0] beat_addr
);
    always_comb begin
        beat_addr      = base;
        beat_addr[1:0] = burst_lo(base[1:0], beat, ord);
    end
endmodule

// File: rtl/fzb_lane_mem.sv
module fzb_lane_mem #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 4
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [LANES-1:0]         wmask,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [LANES*LANE_W-1:0]  wword,
    input  logic [ADDR_W-1:0]        raddr,
    output logic [LANES*LANE_W-1:0]  rword
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wmask[g]) cells[waddr] <= wword[g*LANE_W +: LANE_W];
        end

        assign rword[g*LANE_W +: LANE_W] = cells[raddr];
    end
endmodule

// File: rtl/fzb_bypass.sv
module fzb_bypass #(
    parameter int LANE_W = 9,
    parameter int LANES  = 4
) (
    input  logic                     hit,
    input  logic [LANES-1:0]         mask,
    input  logic [LANES*LANE_W-1:0]  pend_word,
    input  logic [LANES*LANE_W-1:0]  array_word,
    output logic [LANES*LANE_W-1:0]  merged
);
    for (genvar g = 0; g < LANES; g++) begin : g_mux
        assign merged[g*LANE_W +: LANE_W] = (hit && mask[g])
                                          ? pend_word[g*LANE_W +: LANE_W]
                                          : array_word[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/fzb_sram.sv
module fzb_sram
    import fzb_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clk_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     wr_n,
    input  logic [LANES-1:0]         lane_n,
    input  logic                     burst_adv,
    input  logic                     order_sel,
    input  logic                     sel1_n,
    input  logic                     sel2,
    input  logic                     sel3_n,
    input  logic                     out_en_n,
    input  logic [LANES*LANE_W-1:0]  wdata,
    output logic [LANES*LANE_W-1:0]  rdata,
    output logic                     drive_en
);
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        logic              act_vld;
        logic              act_wr;
        logic [ADDR_W-1:0] act_addr;
        logic              bst_live;
        logic              bst_wr;
        burst_order_e      bst_ord;
        logic [ADDR_W-1:0] bst_base;
        logic [1:0]        bst_k;
        logic              pnd_vld;
        logic [ADDR_W-1:0] pnd_addr;
        logic [DATA_W-1:0] pnd_data;
        logic [LANES-1:0]  pnd_mask;
    } state_t;

    state_t st_d, st_q;

    logic              selected;
    logic [1:0]        k_next;
    logic [ADDR_W-1:0] adv_addr;
    logic [DATA_W-1:0] array_word;
    logic [DATA_W-1:0] read_word;
    logic              pnd_hit;

    assign selected = ~sel1_n & sel2 & ~sel3_n;
    assign k_next   = st_q.bst_k + 2'd1;

    fzb_burst_addr #(.ADDR_W(ADDR_W)) addr_i (
        .base      (st_q.bst_base),
        .beat      (k_next),
        .ord       (st_q.bst_ord),
        .beat_addr (adv_addr)
    );

    always_comb begin
        st_d = st_q;

        // data phase of the command captured last edge
        st_d.pnd_vld = st_q.act_vld & st_q.act_wr;
        if (st_q.act_vld && st_q.act_wr) begin
            st_d.pnd_addr = st_q.act_addr;
            st_d.pnd_data = wdata;
            st_d.pnd_mask = ~lane_n;
        end

        // command phase
        if (!selected) begin
            st_d.act_vld  = 1'b0;
            st_d.bst_live = 1'b0;
        end else if (!burst_adv) begin
            st_d.act_vld  = 1'b1;
            st_d.act_wr   = ~wr_n;
            st_d.act_addr = addr;
            st_d.bst_live = 1'b1;
            st_d.bst_wr   = ~wr_n;
            st_d.bst_ord  = burst_order_e'(order_sel);
            st_d.bst_base = addr;
            st_d.bst_k    = 2'd0;
        end else if (st_q.bst_live) begin
            st_d.act_vld  = 1'b1;
            st_d.act_wr   = st_q.bst_wr;
            st_d.act_addr = adv_addr;
            st_d.bst_k    = k_next;
        end else begin
            st_d.act_vld  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      st_q <= '0;
        else if (clk_en) st_q <= st_d;
    end

    fzb_lane_mem #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) mem_i (
        .clk   (clk),
        .we    (rst_n & clk_en & st_q.pnd_vld),
        .wmask (st_q.pnd_mask),
        .waddr (st_q.pnd_addr),
        .wword (st_q.pnd_data),
        .raddr (st_q.act_addr),
        .rword (array_word)
    );

    assign pnd_hit = st_q.pnd_vld && (st_q.pnd_addr == st_q.act_addr);

    fzb_bypass #(.LANE_W(LANE_W), .LANES(LANES)) byp_i (
        .hit        (pnd_hit),
        .mask       (st_q.pnd_mask),
        .pend_word  (st_q.pnd_data),
        .array_word (array_word),
        .merged     (read_word)
    );

    assign drive_en = st_q.act_vld & ~st_q.act_wr & ~out_en_n;
    assign rdata    = drive_en ? read_word : '0;

endmodule

// File: rtl/fzb_sram_chk.sv
module fzb_sram_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic              wr_n,
    input logic              burst_adv,
    input logic              sel1_n,
    input logic              sel2,
    input logic              sel3_n,
    input logic              out_en_n,
    input logic [DATA_W-1:0] rdata,
    input logic              drive_en
);
    logic sel_in;
    assign sel_in = ~sel1_n & sel2 & ~sel3_n;

    AST_WRITE_PHASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && sel_in && !burst_adv && !wr_n) |=> !drive_en); // R6

    AST_DESELECT_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !sel_in) |=> (!drive_en && rdata == '0)); // R7

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && sel_in && !burst_adv && wr_n) |=> (out_en_n || drive_en)); // R2

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && !out_en_n) |=> (out_en_n || ($stable(rdata) && $stable(drive_en)))); // R11

    AST_ADV_AFTER_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && sel_in && burst_adv && $past(clk_en && !sel_in)) |=> !drive_en); // R10

    always_comb begin
        if (rst_n && out_en_n) begin
            AST_OE_FORCES_OFF: assert (!drive_en && rdata == '0); // R8
        end
    end
endmodule

bind fzb_sram fzb_sram_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/fzb_sram_tb.sv
module fzb_sram_tb_top;
    localparam int AW = 6;
    localparam int DW = 36;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          wr_n = 1'b1;
    logic [3:0]    lane_n = 4'hF;
    logic          burst_adv = 1'b0;
    logic          order_sel = 1'b0;
    logic          sel1_n = 1'b1;
    logic          sel2 = 1'b0;
    logic          sel3_n = 1'b1;
    logic          out_en_n = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          drive_en;

    fzb_sram dut_i (.*);

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;

    // bench reference model
    logic [DW-1:0] ref_mem [DEPTH];
    bit            pw_valid = 0;
    logic [AW-1:0] pw_addr;
    bit            b_live = 0;
    bit            b_wr;
    bit            b_mode;
    logic [AW-1:0] b_base;
    int            b_k;
    bit            e_rd = 0;
    logic [DW-1:0] e_word = '0;

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                            input logic [DW-1:0] new_w,
                                            input logic [3:0] ln);
        logic [DW-1:0] r = old_w;
        for (int i = 0; i < 4; i++)
            if (!ln[i]) r[i*9 +: 9] = new_w[i*9 +: 9];
        return r;
    endfunction

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        return DW'((a + 1) * 36'h1_0F1E_2D3) ^ DW'(salt * 36'h5_A5A5_A5A) ^ 36'h3_C3C3_C3C;
    endfunction

    task automatic compare_out(input string req);
        bit drv = e_rd && !out_en_n;
        check(drive_en == drv, req, DW'(drive_en), DW'(drv));
        if (drv) check(rdata == e_word, req, rdata, e_word);
        else     check(rdata == '0, req, rdata, '0);
    endtask

    // one clock: inputs applied now (after a falling edge), outputs checked at next falling edge
    task automatic cyc(input bit en, input bit [2:0] ce, input bit adv, input bit wr,
                       input logic [AW-1:0] a, input logic [DW-1:0] wd,
                       input logic [3:0] ln, input bit md, input string req);
        bit act = 0;
        bit awr = 0;
        logic [AW-1:0] ca = a;
        clk_en = en; sel1_n = ~ce[0]; sel2 = ce[1]; sel3_n = ~ce[2];
        burst_adv = adv; wr_n = ~wr; addr = a; wdata = wd; lane_n = ln; order_sel = md;
        @(posedge clk);
        @(negedge clk);
        if (en) begin
            if (pw_valid) begin
                ref_mem[pw_addr] = merge(ref_mem[pw_addr], wd, ln);
                pw_valid = 0;
            end
            if (ce != 3'b111) begin
                b_live = 0;
            end else if (!adv) begin
                act = 1; awr = wr; ca = a;
                b_live = 1; b_wr = wr; b_mode = md; b_base = a; b_k = 0;
            end else if (b_live) begin
                b_k = (b_k + 1) % 4;
                act = 1; awr = b_wr;
                ca = b_base;
                ca[1:0] = b_mode ? (b_base[1:0] ^ 2'(b_k)) : 2'((b_base[1:0] + b_k) % 4);
            end
            if (act && awr) begin
                pw_valid = 1;
                pw_addr  = ca;
            end
            e_rd = act && !awr;
            if (e_rd) e_word = ref_mem[ca];
        end
        compare_out(req);
    endtask

    task automatic ld(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                      input logic [3:0] ln, input bit md, input string req);
        cyc(1, 3'b111, 0, wr, a, wd, ln, md, req);
    endtask

    task automatic advc(input logic [DW-1:0] wd, input logic [3:0] ln, input string req);
        cyc(1, 3'b111, 1, 0, '0, wd, ln, 0, req);
    endtask

    task automatic idle(input logic [DW-1:0] wd, input logic [3:0] ln, input string req);
        cyc(1, 3'b000, 0, 0, '0, wd, ln, 0, req);
    endtask

    initial begin : watchdog
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(drive_en == 1'b0, "R1", DW'(drive_en), '0);
        check(rdata == '0, "R1", rdata, '0);
        idle('0, 4'hF, "R1");

        // R10: advance with no live burst after reset stays idle
        advc('0, 4'hF, "R10");

        // R3/R4: back-to-back full fill, data one edge after address
        for (int a = 0; a < DEPTH; a++)
            ld(1, AW'(a), (a == 0) ? '0 : pat(a - 1, 0), 4'h0, 0, "R3");
        // R5: immediate read of the last written address (bypass)
        ld(0, AW'(DEPTH - 1), pat(DEPTH - 1, 0), 4'h0, 0, "R5");
        // R2: back-to-back readback of every word
        for (int a = 0; a < DEPTH; a++)
            ld(0, AW'(a), '0, 4'hF, 0, "R2");

        // R4/R5/R3: every lane pattern, write then immediate read then later read
        for (int m = 0; m < 16; m++) begin
            ld(1, AW'(m + 8), '0, 4'hF, 0, "R4");
            ld(0, AW'(m + 8), pat(m, 7), 4'(m), 0, "R5");
            ld(0, AW'(m + 40), '0, 4'hF, 0, "R4");
            ld(0, AW'(m + 8), '0, 4'hF, 0, "R3");
        end

        // R9/R10/R6: bursts in both orders from every start offset
        for (int md = 0; md < 2; md++) begin
            for (int st = 0; st < 4; st++) begin
                ld(1, AW'(32 + 4 * md + st), '0, 4'hF, md[0], "R6");
                for (int k = 1; k < 4; k++)
                    advc(pat(k - 1, 16 + st + 4 * md), 4'h0, "R10");
                ld(0, AW'(32 + 4 * md + st), pat(3, 16 + st + 4 * md), 4'h0, md[0], "R9");
                for (int k = 1; k < 6; k++)
                    advc('0, 4'hF, "R9");
            end
        end

        // R11: stall in a read burst holds output and position
        ld(0, AW'(20), '0, 4'hF, 0, "R11");
        advc('0, 4'hF, "R11");
        for (int s = 0; s < 3; s++)
            cyc(0, 3'b000, 0, 1, AW'(s), pat(s, 99), 4'h0, 1, "R11");
        advc('0, 4'hF, "R11");
        // R11: stall during a write data phase; wdata ignored until enabled edge
        ld(1, AW'(50), '0, 4'hF, 0, "R11");
        cyc(0, 3'b111, 0, 0, AW'(51), pat(1, 55), 4'h0, 0, "R11");
        cyc(0, 3'b111, 0, 0, AW'(52), pat(2, 55), 4'h0, 0, "R11");
        ld(0, AW'(50), pat(3, 55), 4'h5, 0, "R11");
        ld(0, AW'(50), '0, 4'hF, 0, "R11");

        // R7: each chip-enable combination on a read load
        for (int c = 0; c < 8; c++) begin
            cyc(1, 3'(c), 0, 0, AW'(3), '0, 4'hF, 0, "R7");
            idle('0, 4'hF, "R7");
        end
        // R7/R10: deselect inside a burst ends it
        ld(0, AW'(4), '0, 4'hF, 0, "R7");
        advc('0, 4'hF, "R7");
        idle('0, 4'hF, "R7");
        advc('0, 4'hF, "R10");

        // R8: asynchronous output enable during a read
        ld(0, AW'(9), '0, 4'hF, 0, "R8");
        #1 out_en_n = 1'b1;
        #1 compare_out("R8");
        #1 out_en_n = 1'b0;
        #1 compare_out("R8");
        // R6: write phase with output enable low never drives
        ld(1, AW'(10), '0, 4'hF, 0, "R6");
        ld(0, AW'(10), pat(5, 5), 4'h0, 0, "R6");
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule